// File: doc/BRIEF.md
# BCD Calendar Counter with Carry Flag

This block keeps wall-clock time and date in packed BCD: seconds, minutes, hours, day of week, day of month, month and a four-digit year. A 128 Hz tick strobe drives a 7-bit sub-second counter. Each time that counter wraps, the seconds field advances. The advance ripples through minutes, hours, weekday, day, month, year and century in the same clock edge. Day rollover follows the month length and the Gregorian leap-year rule.

Software reaches the block through a small register bus. A write strobe carries a 4-bit slot number and 16 bits of data, and the selected slot is returned combinationally on `rdata`. Two control registers govern operation:

- **First control register.** Holds a sticky carry flag and a carry interrupt enable. To read all fields consistently, software clears the flag, reads the fields, then checks the flag again. If it is set, a second boundary was crossed during the read and the fields must be read again.
- **Second control register.** Holds the start bit, an enable bit and a self-clearing prescaler reset.

A two-state run-control machine decides whether ticks are counted and whether time fields may be loaded.

- **HALT** (after reset): ticks are ignored and writes to the time slots load the counters directly.
- **RUN**: ticks are counted and writes to the time slots are ignored.
- **Transition START**: HALT to RUN, taken when the second control register is written with its start bit at 1.
- **Transition STOP**: RUN to HALT, taken when the same register is written with its start bit at 0.

Top module: `cal_core`

## Requirements
- R1: After reset, the fields read as follows: sub-second 0, seconds 0x00, minutes 0x00, hours 0x00, weekday 0x00, day 0x01, month 0x01, year 0x2000, both control registers 0, and `carry_irq` is low.
- R2: Slot map. Slot 0 is the sub-second count (bits 6:0). Slots 1 to 6 are seconds, minutes, hours, weekday, day and month (bits 7:0). Slot 7 is the year: the century in BCD in bits 15:8 and the year within the century in BCD in bits 7:0. Slots 8 to 13 read as 0 and ignore writes. Slot 14 is the first control register and slot 15 is the second.
- R3: In HALT, a write to slots 1 to 7 loads that field on the next edge. In RUN, such writes leave the field unchanged.
- R4: The second control register has these bits:
  - Bit 0 is start. Writing 1 takes the START transition and writing 0 takes STOP. It reads back as 1 only in RUN.
  - Bit 3 is an enable bit that is stored and read back.
  - Bit 1, when written as 1, clears the sub-second counter. It reads back as 0.
  - Bit 2 reads as 0.

  Ticks in HALT change nothing.
- R5: In RUN, each tick adds one to the 7-bit binary sub-second count. The tick that takes it from 127 to 0 advances seconds by one.
- R6: Seconds and minutes wrap from 0x59 to 0x00 and carry. Hours wrap from 0x23 to 0x00 and carry into the date. Weekday counts 0x00 to 0x06 and wraps at midnight.
- R7: At midnight the day wraps to 0x01 after the last day of the month and the month advances. Months 04, 06, 09 and 11 have 30 days, month 02 has 28 or 29, and all others have 31. Month 0x12 wraps to 0x01 and advances the year. Year 0x99 wraps to 0x00 and advances the century.
- R8: February has 29 days when the year is divisible by 4, except in years ending in 00 whose century is not divisible by 4.
- R9: The carry flag is bit 7 of the first control register.
  - It is set on every seconds advance.
  - Writing 0 to bit 7 clears it, and writing 1 leaves it unchanged.
  - If a seconds advance and a clearing write fall on the same edge, the flag ends up set.
  - Bit 4 of the same register is the carry interrupt enable and is written as given. The other bits read as 0.
- R10: `carry_irq` is high exactly while the carry flag and the carry interrupt enable are both 1. It stays high until one of them is cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle strobe at 128 Hz |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register slot number |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for the slot on `addr` |
| carry_irq | output | 1 | Carry interrupt request |

## Verification
The embedded properties are checked on every clock cycle:

- fields hold steady when there is neither a step nor a load;
- no seconds advance happens in HALT;
- the sub-second count changes only on a counted tick or a prescaler clear;
- the carry flag rises only after a seconds advance;
- the interrupt stays asserted until a clearing write;
- seconds wrap correctly, and the New Year and 28 February boundaries resolve correctly.

Other behaviour is visible only through the bench's scenarios:

- the 30-day and 31-day month ends;
- a century year that is not a leap year;
- the century carry;
- writes ignored while running;
- read-back of each slot through the bus.

// File: rtl/cal_pkg.sv
package cal_pkg;

    localparam int N_FIELDS = 7;

    typedef enum logic [1:0] {
        ST_HALT = 2'd0,
        ST_RUN  = 2'd1
    } run_state_e;

    typedef struct packed {
        logic [15:0] year;
        logic [7:0]  mon;
        logic [7:0]  day;
        logic [7:0]  wday;
        logic [7:0]  hour;
        logic [7:0]  min;
        logic [7:0]  sec;
    } cal_time_t;

    localparam logic [3:0] SL_SUB  = 4'd0;
    localparam logic [3:0] SL_SEC  = 4'd1;
    localparam logic [3:0] SL_MIN  = 4'd2;
    localparam logic [3:0] SL_HOUR = 4'd3;
    localparam logic [3:0] SL_WDAY = 4'd4;
    localparam logic [3:0] SL_DAY  = 4'd5;
    localparam logic [3:0] SL_MON  = 4'd6;
    localparam logic [3:0] SL_YEAR = 4'd7;
    localparam logic [3:0] SL_CTL1 = 4'd14;
    localparam logic [3:0] SL_CTL2 = 4'd15;

    // Returns {wrapped, next value} for a two-digit BCD field.
    function automatic logic [8:0] bcd_step(input logic [7:0] v,
                                            input logic [7:0] last,
                                            input logic [7:0] first);
        if (v == last)
            return {1'b1, first};
        else if (v[3:0] == 4'd9)
            return {1'b0, v[7:4] + 4'd1, 4'd0};
        else
            return {1'b0, v[7:4], v[3:0] + 4'd1};
    endfunction

    function automatic logic [7:0] bcd_bin(input logic [7:0] v);
        return 8'(v[7:4]) * 8'd10 + 8'(v[3:0]);
    endfunction

    function automatic logic is_leap(input logic [15:0] y);
        logic [7:0] cen;
        logic [7:0] yy;
        cen = bcd_bin(y[15:8]);
        yy  = bcd_bin(y[7:0]);
        if (yy != 8'd0)
            return yy[1:0] == 2'd0;
        else
            return cen[1:0] == 2'd0;
    endfunction

    function automatic logic [7:0] month_last(input logic [7:0] m, input logic lp);
        case (m)
            8'h02:                      return lp ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
            default:                    return 8'h31;
        endcase
    endfunction

endpackage

// File: rtl/cal_subsec.sv
module cal_subsec #(
    parameter int SUB_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             tick,
    input  logic             clr,
    output logic [SUB_W-1:0] cnt,
    output logic             wrap
);
    localparam logic [SUB_W-1:0] TOP = '1;

    logic count_now;

    assign count_now = run && tick && !clr;
    assign wrap      = count_now && (cnt == TOP);

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (clr)
            cnt <= '0;
        else if (count_now)
            cnt <= cnt + 1'b1;
    end

    // R4: prescaler reset empties the counter
    p_presc_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt == '0));

    // R5: the count only moves on a counted tick or a clear
    p_moves_on_tick_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (run && tick && !clr && cnt != TOP) |=> (cnt != '0));

    p_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!(run && tick) && !clr) |=> $stable(cnt));

endmodule

// File: rtl/cal_chain.sv
module cal_chain
    import cal_pkg::*;
#(
    parameter int NF = N_FIELDS
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            step,
    input  logic [NF-1:0]   ld_en,
    input  logic [15:0]     ld_data,
    output cal_time_t       cur
);
    logic [8:0] r_sec, r_min, r_hr, r_wd, r_day, r_mon, r_yl, r_yh;
    logic       c_min, c_hr, c_day, c_mon, c_yr, c_cen;
    logic       leap_now;

    assign leap_now = is_leap(cur.year);

    assign r_sec = bcd_step(cur.sec,        8'h59, 8'h00);
    assign r_min = bcd_step(cur.min,        8'h59, 8'h00);
    assign r_hr  = bcd_step(cur.hour,       8'h23, 8'h00);
    assign r_wd  = bcd_step(cur.wday,       8'h06, 8'h00);
    assign r_day = bcd_step(cur.day, month_last(cur.mon, leap_now), 8'h01);
    assign r_mon = bcd_step(cur.mon,        8'h12, 8'h01);
    assign r_yl  = bcd_step(cur.year[7:0],  8'h99, 8'h00);
    assign r_yh  = bcd_step(cur.year[15:8], 8'h99, 8'h00);

    assign c_min = step  && r_sec[8];
    assign c_hr  = c_min && r_min[8];
    assign c_day = c_hr  && r_hr[8];
    assign c_mon = c_day && r_day[8];
    assign c_yr  = c_mon && r_mon[8];
    assign c_cen = c_yr  && r_yl[8];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur.sec  <= 8'h00;
            cur.min  <= 8'h00;
            cur.hour <= 8'h00;
            cur.wday <= 8'h00;
            cur.day  <= 8'h01;
            cur.mon  <= 8'h01;
            cur.year <= 16'h2000;
        end else begin
            if (ld_en[0])      cur.sec  <= ld_data[7:0];
            else if (step)     cur.sec  <= r_sec[7:0];
            if (ld_en[1])      cur.min  <= ld_data[7:0];
            else if (c_min)    cur.min  <= r_min[7:0];
            if (ld_en[2])      cur.hour <= ld_data[7:0];
            else if (c_hr)     cur.hour <= r_hr[7:0];
            if (ld_en[3])      cur.wday <= ld_data[7:0];
            else if (c_day)    cur.wday <= r_wd[7:0];
            if (ld_en[4])      cur.day  <= ld_data[7:0];
            else if (c_day)    cur.day  <= r_day[7:0];
            if (ld_en[5])      cur.mon  <= ld_data[7:0];
            else if (c_mon)    cur.mon  <= r_mon[7:0];
            if (ld_en[6])      cur.year <= ld_data;
            else begin
                if (c_yr)      cur.year[7:0]  <= r_yl[7:0];
                if (c_cen)     cur.year[15:8] <= r_yh[7:0];
            end
        end
    end

    // R3: nothing moves without a step or a load
    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && ld_en == '0) |=> $stable(cur));

    // R6: seconds wrap
    p_sec_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (step && cur.sec == 8'h59) |=> (cur.sec == 8'h00));

    // R7: New Year resolves in one edge
    p_newyear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (c_day && cur.mon == 8'h12 && cur.day == 8'h31)
        |=> (cur.mon == 8'h01 && cur.day == 8'h01));

    // R8: leap day follows 28 February in a leap year
    p_leap_day_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (c_day && cur.mon == 8'h02 && cur.day == 8'h28 && leap_now)
        |=> (cur.day == 8'h29 && cur.mon == 8'h02));

endmodule

// File: rtl/cal_ctrl.sv
module cal_ctrl
    import cal_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr1,
    input  logic       wr2,
    input  logic [7:0] wdata,
    input  logic       sec_step,
    output logic       run,
    output logic       presc_clr,
    output logic       cf,
    output logic       cie,
    output logic       en,
    output logic       irq
);
    run_state_e st_q, st_d;

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= ST_HALT;
        else
            st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_HALT: if (wr2 && wdata[0])  st_d = ST_RUN;   // START
            ST_RUN:  if (wr2 && !wdata[0]) st_d = ST_HALT;  // STOP
            default: st_d = ST_HALT;
        endcase
    end

    always_comb begin
        run       = (st_q == ST_RUN);
        presc_clr = wr2 && wdata[1];
        irq       = cf && cie;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cf  <= 1'b0;
            cie <= 1'b0;
            en  <= 1'b0;
        end else begin
            if (sec_step)
                cf <= 1'b1;
            else if (wr1 && !wdata[7])
                cf <= 1'b0;
            if (wr1) cie <= wdata[4];
            if (wr2) en  <= wdata[3];
        end
    end

    // R4: no seconds advance while halted
    p_halt_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_HALT) |-> !sec_step);

    // R9: flag rises only after a seconds advance
    p_cf_source_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cf) |-> $past(sec_step));

    p_cf_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr1 && !wdata[7] && !sec_step) |=> !cf);

    // R10: request stays up until a clearing write
    p_irq_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !(wr1 && (!wdata[7] || !wdata[4]))) |=> irq);

endmodule

// File: rtl/cal_core.sv
module cal_core
    import cal_pkg::*;
#(
    parameter int SUB_W  = 7,
    parameter int DATA_W = 16,
    parameter int SLOT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              wr_en,
    input  logic [SLOT_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              carry_irq
);
    logic [SUB_W-1:0]    sub_cnt;
    logic                sec_step;
    logic                run, presc_clr, cf, cie, en;
    logic                wr1, wr2;
    logic [N_FIELDS-1:0] ld_en;
    cal_time_t           now;

    assign wr1 = wr_en && (addr == SL_CTL1);
    assign wr2 = wr_en && (addr == SL_CTL2);

    for (genvar i = 0; i < N_FIELDS; i++) begin : g_ld
        assign ld_en[i] = wr_en && !run && (addr == SLOT_W'(i + 1));
    end

    cal_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr1       (wr1),
        .wr2       (wr2),
        .wdata     (wdata[7:0]),
        .sec_step  (sec_step),
        .run       (run),
        .presc_clr (presc_clr),
        .cf        (cf),
        .cie       (cie),
        .en        (en),
        .irq       (carry_irq)
    );

    cal_subsec #(.SUB_W(SUB_W)) u_sub (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .tick  (tick),
        .clr   (presc_clr),
        .cnt   (sub_cnt),
        .wrap  (sec_step)
    );

    cal_chain u_chain (
        .clk     (clk),
        .rst_n   (rst_n),
        .step    (sec_step),
        .ld_en   (ld_en),
        .ld_data (wdata),
        .cur     (now)
    );

    always_comb begin
        rdata = '0;
        case (addr)
            SL_SUB:  rdata = DATA_W'(sub_cnt);
            SL_SEC:  rdata = DATA_W'(now.sec);
            SL_MIN:  rdata = DATA_W'(now.min);
            SL_HOUR: rdata = DATA_W'(now.hour);
            SL_WDAY: rdata = DATA_W'(now.wday);
            SL_DAY:  rdata = DATA_W'(now.day);
            SL_MON:  rdata = DATA_W'(now.mon);
            SL_YEAR: rdata = DATA_W'(now.year);
            SL_CTL1: rdata = DATA_W'({cf, 2'b00, cie, 4'b0000});
            SL_CTL2: rdata = DATA_W'({4'b0000, en, 1'b0, 1'b0, run});
            default: rdata = '0;
        endcase
    end

endmodule

// File: tb/sim_cal_core.sv
module sim_cal_core;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  addr = 4'd0;
    logic [15:0] wdata = 16'h0;
    logic [15:0] rdata;
    logic        carry_irq;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    cal_core u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .wr_en     (wr_en),
        .addr      (addr),
        .wdata     (wdata),
        .rdata     (rdata),
        .carry_irq (carry_irq)
    );

    always #10 clk = ~clk;

    task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic expect_reg(input string req, input logic [3:0] a, input logic [15:0] exp);
        addr = a;
        #1;
        check(req, rdata, exp);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick = 1'b1;
            @(negedge clk); tick = 1'b0;
        end
    endtask

    task automatic set_time(input logic [7:0] s, input logic [7:0] m, input logic [7:0] h,
                            input logic [7:0] wd, input logic [7:0] d, input logic [7:0] mo,
                            input logic [15:0] y);
        wr(4'd1, {8'h0, s});
        wr(4'd2, {8'h0, m});
        wr(4'd3, {8'h0, h});
        wr(4'd4, {8'h0, wd});
        wr(4'd5, {8'h0, d});
        wr(4'd6, {8'h0, mo});
        wr(4'd7, y);
    endtask

    task automatic t_reset;
        expect_reg("R1 sub", 4'd0, 16'h0000);
        expect_reg("R1 sec", 4'd1, 16'h0000);
        expect_reg("R1 wday", 4'd4, 16'h0000);
        expect_reg("R1 day", 4'd5, 16'h0001);
        expect_reg("R1 month", 4'd6, 16'h0001);
        expect_reg("R1 year", 4'd7, 16'h2000);
        expect_reg("R1 ctl1", 4'd14, 16'h0000);
        expect_reg("R1 ctl2", 4'd15, 16'h0000);
        check("R1 irq", {15'h0, carry_irq}, 16'h0000);
    endtask

    task automatic t_load_map;
        set_time(8'h12, 8'h34, 8'h05, 8'h02, 8'h17, 8'h08, 16'h2031);
        expect_reg("R3 sec load", 4'd1, 16'h0012);
        expect_reg("R2 min slot", 4'd2, 16'h0034);
        expect_reg("R2 hour slot", 4'd3, 16'h0005);
        expect_reg("R2 wday slot", 4'd4, 16'h0002);
        expect_reg("R2 day slot", 4'd5, 16'h0017);
        expect_reg("R2 month slot", 4'd6, 16'h0008);
        expect_reg("R2 year slot", 4'd7, 16'h2031);
        wr(4'd9, 16'h00A5);
        expect_reg("R2 alarm slot reads 0", 4'd9, 16'h0000);
        wr(4'd15, 16'h0009);
        expect_reg("R4 ctl2 running", 4'd15, 16'h0009);
        wr(4'd1, 16'h0044);
        expect_reg("R3 write ignored in RUN", 4'd1, 16'h0012);
        wr(4'd15, 16'h0008);
    endtask

    task automatic t_halt_presc;
        ticks(200);
        expect_reg("R4 halted sub", 4'd0, 16'h0000);
        expect_reg("R4 halted sec", 4'd1, 16'h0012);
        wr(4'd15, 16'h0009);
        ticks(10);
        expect_reg("R5 sub counts", 4'd0, 16'h000A);
        wr(4'd15, 16'h000B);
        expect_reg("R4 prescaler clear", 4'd0, 16'h0000);
        expect_reg("R4 reset bit reads 0", 4'd15, 16'h0009);
        ticks(127);
        expect_reg("R5 sec before wrap", 4'd1, 16'h0012);
        ticks(1);
        expect_reg("R5 sec after wrap", 4'd1, 16'h0013);
        expect_reg("R5 sub wrapped", 4'd0, 16'h0000);
        wr(4'd15, 16'h0000);
    endtask

    task automatic t_carry;
        wr(4'd14, 16'h0000);
        expect_reg("R9 flag cleared", 4'd14, 16'h0000);
        wr(4'd15, 16'h0001);
        ticks(128);
        expect_reg("R9 flag set by second", 4'd14, 16'h0080);
        check("R10 irq low without enable", {15'h0, carry_irq}, 16'h0000);
        wr(4'd14, 16'h0090);
        expect_reg("R9 writing 1 keeps flag", 4'd14, 16'h0090);
        check("R10 irq high", {15'h0, carry_irq}, 16'h0001);
        wr(4'd14, 16'h0010);
        expect_reg("R9 clear keeps enable", 4'd14, 16'h0010);
        check("R10 irq drops", {15'h0, carry_irq}, 16'h0000);
        wr(4'd15, 16'h0000);
    endtask

    task automatic roll(input string req, input logic [7:0] d, input logic [7:0] mo,
                        input logic [15:0] y, input logic [7:0] exp_d,
                        input logic [7:0] exp_mo, input logic [15:0] exp_y);
        set_time(8'h59, 8'h59, 8'h23, 8'h03, d, mo, y);
        wr(4'd15, 16'h0001);
        ticks(128);
        expect_reg({req, " day"}, 4'd5, {8'h0, exp_d});
        expect_reg({req, " month"}, 4'd6, {8'h0, exp_mo});
        expect_reg({req, " year"}, 4'd7, exp_y);
        wr(4'd15, 16'h0000);
    endtask

    task automatic t_midnight;
        set_time(8'h59, 8'h59, 8'h23, 8'h06, 8'h31, 8'h12, 16'h1999);
        wr(4'd15, 16'h0001);
        ticks(128);
        expect_reg("R6 sec wrap", 4'd1, 16'h0000);
        expect_reg("R6 min wrap", 4'd2, 16'h0000);
        expect_reg("R6 hour wrap", 4'd3, 16'h0000);
        expect_reg("R6 wday wrap", 4'd4, 16'h0000);
        expect_reg("R7 new year day", 4'd5, 16'h0001);
        expect_reg("R7 new year month", 4'd6, 16'h0001);
        expect_reg("R7 century carry", 4'd7, 16'h2000);
        wr(4'd15, 16'h0000);
        set_time(8'h59, 8'h59, 8'h22, 8'h03, 8'h10, 8'h05, 16'h2023);
        wr(4'd15, 16'h0001);
        ticks(128);
        expect_reg("R6 hour carry", 4'd3, 16'h0023);
        expect_reg("R6 wday held", 4'd4, 16'h0003);
        wr(4'd15, 16'h0000);
    endtask

    task automatic t_months;
        roll("R7 30-day April", 8'h30, 8'h04, 16'h2023, 8'h01, 8'h05, 16'h2023);
        roll("R7 31-day January", 8'h31, 8'h01, 16'h2023, 8'h01, 8'h02, 16'h2023);
        roll("R7 not end of month", 8'h30, 8'h01, 16'h2023, 8'h31, 8'h01, 16'h2023);
        roll("R7 year 2099 to 2100", 8'h31, 8'h12, 16'h2099, 8'h01, 8'h01, 16'h2100);
        expect_reg("R6 wday advances", 4'd4, 16'h0004);
    endtask

    task automatic t_leap;
        roll("R8 2000 leap", 8'h28, 8'h02, 16'h2000, 8'h29, 8'h02, 16'h2000);
        roll("R8 2100 not leap", 8'h28, 8'h02, 16'h2100, 8'h01, 8'h03, 16'h2100);
        roll("R8 2024 leap", 8'h28, 8'h02, 16'h2024, 8'h29, 8'h02, 16'h2024);
        roll("R8 2024 leap day end", 8'h29, 8'h02, 16'h2024, 8'h01, 8'h03, 16'h2024);
        roll("R8 2023 common", 8'h28, 8'h02, 16'h2023, 8'h01, 8'h03, 16'h2023);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_load_map;
        t_halt_presc;
        t_carry;
        t_midnight;
        t_months;
        t_leap;
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule